// File: doc/BRIEF.md
# Complementary Dead-Band Soft-Start Generator

This block turns one square-wave phase signal into a pair of active-high, non-overlapping gate drives. The high-side drive copies the input, but its rising edge is held back by a delay. The low-side drive copies the inverted input, held back by the same delay after each falling edge of the input. The delay is one value that both sides share, counted in clock cycles. Either drive conducts for the input's high (or low) time minus the delay, and it stays off for a whole half-cycle when that half-cycle is not longer than the delay.

The same delay also limits the duty cycle during start-up. After reset, or on a soft-start request, the next cycle-start strobe loads a delay equal to floor(19/20 of the time-base period). The input toggles once per time-base period, so each drive then conducts for about 5% of its half-cycle. Each later cycle-start strobe lowers the delay by a programmable step, never going below the normal dead time, so the conduction time ramps up toward the full 50% point. A done flag reports when the ramp has settled on the normal dead time.

Top module: `dbsoft_gen`

## Requirements
- R1: While reset is asserted, hiOut, loOut and ssDone are all 0. After reset they stay 0 until the first cycleStart, whatever pwmIn does.
- R2: hiOut is pwmIn with one cycle of latency, and its rising edge is held back by the applied delay D. A high time of T cycles on pwmIn gives T-D high cycles on hiOut.
- R3: loOut is the inverse of pwmIn with one cycle of latency, and its rising edge is held back by D. A low time of T cycles on pwmIn gives T-D high cycles on loOut.
- R4: hiOut and loOut are never high in the same cycle.
- R5: When an input half-cycle is not longer than D, the matching output stays low for that whole half-cycle.
- R6: The first cycleStart after reset, or after a softStartReq pulse, applies D = max(floor(tbPeriod*19/20), normalDb).
- R7: At every other cycleStart, D becomes D-stepSize if that value is still above normalDb, and normalDb otherwise. A stepSize of 0 keeps D where it is while it is above normalDb.
- R8: D changes only at cycleStart. Changing normalDb, stepSize or tbPeriod between strobes has no effect on the pulse in progress.
- R9: At each cycleStart, ssDone is set to whether the new D equals normalDb. A softStartReq clears ssDone in the following cycle.
- R10: If normalDb is raised above the current D, D becomes normalDb at the next cycleStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmIn | input | 1 | Phase signal to be split into a complementary pair |
| cycleStart | input | 1 | One-cycle strobe on the first high cycle of each PWM cycle |
| softStartReq | input | 1 | One-cycle request to restart the ramp from the start-up delay |
| tbPeriod | input | 10 | Time-base period in clocks (pwmIn half-cycle length) |
| normalDb | input | 10 | Normal dead time in clocks |
| stepSize | input | 10 | Delay decrement applied at each cycleStart |
| hiOut | output | 1 | High-side drive |
| loOut | output | 1 | Low-side drive |
| ssDone | output | 1 | Delay has settled on normalDb |

## Verification
The assertions assume that cycleStart is pulsed on the first cycle of each PWM cycle in which pwmIn is high, that normalDb is at least 1, and that softStartReq never arrives in the same cycle as cycleStart. Under these conditions, a change of delay at the strobe can never open an output early. The stimulus builds every PWM cycle the same way: cycleStart on step 0 of the high phase, and a soft-start request only while pwmIn is low, between cycles. Every normalDb it uses is 2 or more.

// File: rtl/dbsoft_pkg.sv
package dbsoft_pkg;
  localparam int DB_W = 10;

  // control-to-datapath bus
  typedef struct packed {
    logic             armed;  // outputs allowed after first cycle start
    logic [DB_W-1:0]  delay;  // delay applied in the current PWM cycle
  } dbCtrl_t;
endpackage

// File: rtl/dbsoft_ctrl.sv
module dbsoft_ctrl
  import dbsoft_pkg::*;
#(
  parameter int START_NUM = 19,
  parameter int START_DEN = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cycleStart,
  input  logic            softStartReq,
  input  logic [DB_W-1:0] tbPeriod,
  input  logic [DB_W-1:0] normalDb,
  input  logic [DB_W-1:0] stepSize,
  output dbCtrl_t         ctrlBus,
  output logic            ssDone
);
  localparam int PW = DB_W + $clog2(START_NUM + 1);

  logic            startPend;
  logic            armedQ;
  logic [DB_W-1:0] appliedQ;
  logic [DB_W-1:0] startVal;
  logic [DB_W-1:0] nextDelay;
  logic            doneQ;

  // start-up delay: a fixed fraction of the time-base period
  assign startVal = DB_W'((PW'(tbPeriod) * PW'(START_NUM)) / PW'(START_DEN));

  always_comb begin
    if (startPend) begin
      nextDelay = (startVal > normalDb) ? startVal : normalDb;
    end else if ((appliedQ > normalDb) && ((appliedQ - normalDb) > stepSize)) begin
      nextDelay = appliedQ - stepSize;
    end else begin
      nextDelay = normalDb;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPend <= 1'b1;
      armedQ    <= 1'b0;
      appliedQ  <= '0;
      doneQ     <= 1'b0;
    end else begin
      startPend <= softStartReq | (startPend & ~cycleStart);
      if (cycleStart) begin
        armedQ   <= 1'b1;
        appliedQ <= nextDelay;
      end
      if (softStartReq) begin
        doneQ <= 1'b0;
      end else if (cycleStart) begin
        doneQ <= (nextDelay == normalDb);
      end
    end
  end

  assign ctrlBus.armed = armedQ;
  assign ctrlBus.delay = appliedQ;
  assign ssDone        = doneQ;
endmodule

// File: rtl/dbsoft_edge.sv
module dbsoft_edge #(
  parameter int W      = 10,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         srcIn,
  input  logic [W-1:0] delay,
  output logic         drvOut
);
  logic         active;
  logic [W-1:0] runCnt;

  assign active = srcIn ^ INVERT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      drvOut <= 1'b0;
    end else begin
      if (!active) begin
        runCnt <= '0;
      end else if (runCnt != '1) begin
        runCnt <= runCnt + 1'b1;
      end
      drvOut <= enable && active && (runCnt >= delay);
    end
  end
endmodule

// File: rtl/dbsoft_datapath.sv
module dbsoft_datapath
  import dbsoft_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwmIn,
  input  dbCtrl_t ctrlBus,
  output logic    hiOut,
  output logic    loOut
);
  logic [1:0] drv;

  // side 0 follows the input, side 1 follows its inverse
  for (genvar g = 0; g < 2; g++) begin : g_side
    dbsoft_edge #(
      .W      (DB_W),
      .INVERT (g == 1)
    ) u_edge (
      .clk    (clk),
      .rstN   (rstN),
      .enable (ctrlBus.armed),
      .srcIn  (pwmIn),
      .delay  (ctrlBus.delay),
      .drvOut (drv[g])
    );
  end

  assign hiOut = drv[0];
  assign loOut = drv[1];
endmodule

// File: rtl/dbsoft_gen.sv
module dbsoft_gen
  import dbsoft_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            pwmIn,
  input  logic            cycleStart,
  input  logic            softStartReq,
  input  logic [DB_W-1:0] tbPeriod,
  input  logic [DB_W-1:0] normalDb,
  input  logic [DB_W-1:0] stepSize,
  output logic            hiOut,
  output logic            loOut,
  output logic            ssDone
);
  dbCtrl_t ctrlBus;

  dbsoft_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cycleStart   (cycleStart),
    .softStartReq (softStartReq),
    .tbPeriod     (tbPeriod),
    .normalDb     (normalDb),
    .stepSize     (stepSize),
    .ctrlBus      (ctrlBus),
    .ssDone       (ssDone)
  );

  dbsoft_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pwmIn   (pwmIn),
    .ctrlBus (ctrlBus),
    .hiOut   (hiOut),
    .loOut   (loOut)
  );
endmodule

// File: rtl/dbsoft_gen_chk.sv
module dbsoft_gen_chk (
  input logic clk,
  input logic rstN,
  input logic pwmIn,
  input logic cycleStart,
  input logic softStartReq,
  input logic hiOut,
  input logic loOut,
  input logic ssDone
);
  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!hiOut && !loOut && !ssDone); // R1
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(hiOut && loOut)); // R4

  AST_HI_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rstN)
    hiOut |-> $past(pwmIn)); // R2

  AST_LO_FOLLOWS_NOT_IN: assert property (@(posedge clk) disable iff (!rstN)
    loOut |-> !$past(pwmIn)); // R3

  AST_DONE_RISE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssDone) |-> $past(cycleStart)); // R9

  AST_REQ_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    softStartReq |=> !ssDone); // R9
endmodule

bind dbsoft_gen dbsoft_gen_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .pwmIn        (pwmIn),
  .cycleStart   (cycleStart),
  .softStartReq (softStartReq),
  .hiOut        (hiOut),
  .loOut        (loOut),
  .ssDone       (ssDone)
);

// File: tb/dbsoft_gen_bench.sv
`timescale 1ns/1ps
module dbsoft_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwmIn = 1'b0;
  logic       cycleStart = 1'b0;
  logic       softStartReq = 1'b0;
  logic [9:0] tbPeriod = 10'd20;
  logic [9:0] normalDb = 10'd2;
  logic [9:0] stepSize = 10'd4;
  logic       hiOut, loOut, ssDone;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dbsoft_gen u_dbsoft_gen (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .cycleStart(cycleStart),
    .softStartReq(softStartReq), .tbPeriod(tbPeriod), .normalDb(normalDb),
    .stepSize(stepSize), .hiOut(hiOut), .loOut(loOut), .ssDone(ssDone)
  );

  // {softReq, period, normalDb, step, expected on-cycles per side, expected done}
  localparam logic [33:0] VEC [0:13] = '{
    {1'b0, 8'd20, 8'd2,  8'd4,  8'd1,  1'b0},
    {1'b0, 8'd20, 8'd2,  8'd4,  8'd5,  1'b0},
    {1'b0, 8'd20, 8'd2,  8'd4,  8'd9,  1'b0},
    {1'b0, 8'd20, 8'd2,  8'd4,  8'd13, 1'b0},
    {1'b0, 8'd20, 8'd2,  8'd4,  8'd17, 1'b0},
    {1'b0, 8'd20, 8'd2,  8'd4,  8'd18, 1'b1},
    {1'b0, 8'd20, 8'd2,  8'd4,  8'd18, 1'b1},
    {1'b1, 8'd40, 8'd3,  8'd10, 8'd2,  1'b0},
    {1'b0, 8'd40, 8'd3,  8'd10, 8'd12, 1'b0},
    {1'b0, 8'd40, 8'd3,  8'd0,  8'd12, 1'b0},
    {1'b0, 8'd40, 8'd3,  8'd10, 8'd22, 1'b0},
    {1'b0, 8'd40, 8'd3,  8'd10, 8'd32, 1'b0},
    {1'b0, 8'd40, 8'd3,  8'd10, 8'd37, 1'b1},
    {1'b0, 8'd40, 8'd30, 8'd10, 8'd10, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_req();
    softStartReq = 1'b1;
    pwmIn = 1'b0;
    @(posedge clk); #1;
    softStartReq = 1'b0;
  endtask

  // one PWM cycle: hiLen high steps then loLen low steps, strobe on step 0
  task automatic run_cycle(input int hiLen, input int loLen, input int chgAt,
                           input int chgNd, output int hc, output int lc);
    hc = 0;
    lc = 0;
    for (int i = 0; i < hiLen + loLen; i++) begin
      pwmIn = (i < hiLen);
      cycleStart = (i == 0);
      if (i == chgAt) normalDb = 10'(chgNd);
      @(posedge clk); #1;
      cycleStart = 1'b0;
      if (hiOut) hc++;
      if (loOut) lc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hc, lc;
    // R1: held in reset
    repeat (3) @(posedge clk);
    #1;
    check("R1 hi in reset", hiOut, 0);
    check("R1 lo in reset", loOut, 0);
    check("R1 done in reset", ssDone, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R1: input toggling without a strobe leaves outputs low
    hc = 0; lc = 0;
    for (int i = 0; i < 30; i++) begin
      pwmIn = (i % 10) < 5;
      @(posedge clk); #1;
      if (hiOut) hc++;
      if (loOut) lc++;
    end
    check("R1 hi before first strobe", hc, 0);
    check("R1 lo before first strobe", lc, 0);

    // R2 R3 R6 R7 R9 R10: table of ramp cycles
    for (int v = 0; v < 14; v++) begin
      tbPeriod = 10'(VEC[v][32:25]);
      normalDb = 10'(VEC[v][24:17]);
      stepSize = 10'(VEC[v][16:9]);
      if (VEC[v][33]) pulse_req();
      run_cycle(int'(VEC[v][32:25]), int'(VEC[v][32:25]), -1, 0, hc, lc);
      check("R2/R6/R7 hi on-cycles", hc, int'(VEC[v][8:1]));
      check("R3/R6/R7 lo on-cycles", lc, int'(VEC[v][8:1]));
      check("R9/R10 done after strobe", ssDone, int'(VEC[v][0]));
    end

    // R9: request clears done in the next cycle
    normalDb = 10'd3;
    tbPeriod = 10'd40;
    stepSize = 10'd10;
    pulse_req();
    check("R9 done cleared by request", ssDone, 0);

    // R5: half-cycles of 10 against an applied delay of 38
    run_cycle(10, 10, -1, 0, hc, lc);
    check("R5 short high pulse", hc, 0);
    check("R5 short low pulse", lc, 0);

    // R8: normalDb changed mid-pulse, delay 28 stays applied
    run_cycle(40, 40, 20, 30, hc, lc);
    check("R8 hi unaffected by mid change", hc, 12);
    check("R8 lo unaffected by mid change", lc, 12);
    check("R8 done unchanged", ssDone, 0);

    // R10: raised normalDb 30 taken at next strobe
    run_cycle(40, 40, -1, 0, hc, lc);
    check("R10 hi on-cycles", hc, 10);
    check("R10 lo on-cycles", lc, 10);
    check("R10 done", ssDone, 1);

    // R5: low half-cycle of 15 shorter than delay 30
    run_cycle(40, 15, -1, 0, hc, lc);
    check("R5 hi long pulse", hc, 10);
    check("R5 lo short pulse", lc, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule